// File: doc/BRIEF.md
# Addressable RGB LED Chain Transmitter

This block drives a single-wire chain of addressable RGB LEDs from a small on-chip pixel store. Software loads a colour into the store with one write. Each write carries 8-bit red, green and blue values and a per-LED select mask, and it lands on every selected LED that lies inside the configured chain length. The chain length can only grow. A write of a smaller count leaves it unchanged, and a request above the build-time maximum is clamped to that maximum.

A send request only arms a pending flag. The frame starts on the next service tick pulse, and only if no frame is already running. The frame is one low lead cell, then 24 data cells per LED, then eight low trail cells. The data cells are green, then red, then blue, most significant bit first, with LED 0 first. Each cell is 20 sub-ticks long, and each sub-tick lasts `SUB_DIV` clocks. A 0 holds the line high for the first 7 sub-ticks of its cell, and a 1 holds it high for the first 14. The busy output is high for exactly the length of the frame. Pixel writes that arrive while busy is high are held back, so a frame never mixes old and new colours.

Top module: `ledchain_tx`

## Requirements
- R1: After reset, `ledOut` and `busy` are low, the chain length is 0 and every pixel is zero, so a frame sent after the length is raised carries only 0 bits.
- R2: Each bit cell lasts 20 sub-ticks of `SUB_DIV` clocks each. A data 0 is high for the first 7 sub-ticks and a data 1 is high for the first 14 sub-ticks. The line is low for the rest of the cell.
- R3: Data cells carry LED 0 first. Within each LED the order is green[7..0], red[7..0], blue[7..0].
- R4: A frame is one low lead cell, then 24×N data cells (N being the chain length latched when the frame starts), then 8 low trail cells. `busy` is high for exactly (24×N+9)×20×`SUB_DIV` clocks.
- R5: A write stores its {green, red, blue} value in every LED i with `wrMask[i]`=1 and i < chain length. Mask bits at or beyond the chain length change nothing.
- R6: A length write sets the chain length to max(old, min(value, `MAX_LEDS`)). It never shrinks the length.
- R7: `sendReq` only arms a pending flag. A frame starts on the clock edge where `svcTick` is high, the flag is already armed and `busy` is low, and the flag is then cleared. A request made during a frame is kept for a later tick.
- R8: Pixel writes made while `busy` is high do not affect the running frame. The most recent such write is applied in the first cycle after `busy` falls, and earlier ones are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Pixel write strobe |
| wrMask | input | MAX_LEDS | LED select mask for the write |
| wrRed | input | 8 | Red value |
| wrGreen | input | 8 | Green value |
| wrBlue | input | 8 | Blue value |
| cntEn | input | 1 | Chain length write strobe |
| cntValue | input | clog2(MAX_LEDS+1) | Requested chain length |
| sendReq | input | 1 | Arms a frame request |
| svcTick | input | 1 | Service tick; a pending frame may start here |
| ledOut | output | 1 | Serial LED data line |
| busy | output | 1 | High while a frame is on the line |

## Verification
A wrong cell or sub-tick count shows up within one bit cell, as a high time other than 7 or 14 sub-ticks or as a frame of the wrong length measured on `busy`. A wrong LED or bit pointer, or a pixel store that is corrupted or written too early, shows up as a single wrong cell in the next frame. The decoder finds it at an exact position in the frame. A lost or stuck pending flag shows up as a frame that never starts, or one that starts without a service tick, and this is visible on `busy` one cycle after the tick.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
  localparam int CELL_SUBS    = 20;
  localparam int HIGH_ZERO    = 7;
  localparam int HIGH_ONE     = 14;
  localparam int TRAIL_PADS   = 8;
  localparam int BITS_PER_LED = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_DATA, ST_TRAIL} txState_t;

  typedef struct packed {
    logic txBusy;      // frame on the line: hold pixel writes
    logic frameStart;  // first cycle of a frame: latch chain length
  } ctlStrobes_t;
endpackage

// File: rtl/ledchain_pixels.sv
module ledchain_pixels
  import ledchain_pkg::*;
#(
  parameter int MAX_LEDS = 16,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic                wrEn,
  input  logic [MAX_LEDS-1:0] wrMask,
  input  logic [7:0]          wrRed,
  input  logic [7:0]          wrGreen,
  input  logic [7:0]          wrBlue,
  input  logic                cntEn,
  input  logic [CNT_W-1:0]    cntValue,
  input  logic [IDX_W-1:0]    rdLed,
  input  logic [4:0]          rdPos,
  output logic                rdBit,
  output logic [CNT_W-1:0]    frameLeds
);
  localparam int PIX_W = MAX_LEDS * BITS_PER_LED;
  localparam int SEL_W = $clog2(PIX_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEDS);

  logic [PIX_W-1:0]        pixQ, pixNext;
  logic [CNT_W-1:0]        countQ, countNext, clampVal;
  logic                    heldV;
  logic [MAX_LEDS-1:0]     heldMask;
  logic [BITS_PER_LED-1:0] heldGrb, newGrb;
  logic [SEL_W-1:0]        rdSel;

  assign newGrb = {wrGreen, wrRed, wrBlue};

  always_comb begin
    clampVal  = (cntValue > CNT_MAX) ? CNT_MAX : cntValue;
    countNext = (clampVal > countQ) ? clampVal : countQ;
  end

  // per-LED update: a released held write first, then a direct write on top
  always_comb begin
    pixNext = pixQ;
    for (int i = 0; i < MAX_LEDS; i++) begin
      if (!ctl.txBusy && heldV && heldMask[i] && (CNT_W'(i) < countQ))
        pixNext[i*BITS_PER_LED +: BITS_PER_LED] = heldGrb;
      if (!ctl.txBusy && wrEn && wrMask[i] && (CNT_W'(i) < countQ))
        pixNext[i*BITS_PER_LED +: BITS_PER_LED] = newGrb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixQ      <= '0;
      countQ    <= '0;
      frameLeds <= '0;
      heldV     <= 1'b0;
      heldMask  <= '0;
      heldGrb   <= '0;
    end else begin
      pixQ <= pixNext;
      if (cntEn) countQ <= countNext;
      if (ctl.frameStart) frameLeds <= countQ;
      if (wrEn && ctl.txBusy) begin
        heldV    <= 1'b1;
        heldMask <= wrMask;
        heldGrb  <= newGrb;
      end else if (!ctl.txBusy) begin
        heldV <= 1'b0;
      end
    end
  end

  // green occupies the top byte of each slice, so position 0 reads bit 23
  assign rdSel = SEL_W'(int'(rdLed) * BITS_PER_LED + (BITS_PER_LED - 1) - int'(rdPos));
  assign rdBit = pixQ[rdSel];

  AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> countQ >= $past(countQ)); // R6
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_MAX); // R6
  AST_PIX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.txBusy && $past(ctl.txBusy)) |-> $stable(pixQ)); // R8
endmodule

// File: rtl/ledchain_ctrl.sv
module ledchain_ctrl
  import ledchain_pkg::*;
#(
  parameter int SUB_DIV = 16,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sendReq,
  input  logic             svcTick,
  input  logic [CNT_W-1:0] frameLeds,
  input  logic             rdBit,
  output ctlStrobes_t      ctl,
  output logic [IDX_W-1:0] rdLed,
  output logic [4:0]       rdPos,
  output logic             ledOut,
  output logic             busy
);
  localparam int DIV_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SUB_DIV - 1);
  localparam logic [4:0] SUB_LAST = 5'(CELL_SUBS - 1);
  localparam logic [4:0] POS_LAST = 5'(BITS_PER_LED - 1);
  localparam logic [3:0] PAD_LAST = 4'(TRAIL_PADS - 1);

  txState_t         state;
  logic [DIV_W-1:0] divQ;
  logic [4:0]       subQ, posQ;
  logic [IDX_W-1:0] ledQ;
  logic [3:0]       padQ;
  logic             pendQ, start, cellEnd, lastLed;

  assign start   = (state == ST_IDLE) && pendQ && svcTick;
  assign cellEnd = (divQ == DIV_LAST) && (subQ == SUB_LAST);
  assign lastLed = (CNT_W'(ledQ) + 1'b1) == frameLeds;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pendQ <= 1'b0;
      divQ  <= '0;
      subQ  <= '0;
      posQ  <= '0;
      ledQ  <= '0;
      padQ  <= '0;
    end else begin
      if (start) pendQ <= sendReq;
      else if (sendReq) pendQ <= 1'b1;
      if (state == ST_IDLE) begin
        if (start) begin
          state <= ST_LEAD;
          divQ  <= '0;
          subQ  <= '0;
          posQ  <= '0;
          ledQ  <= '0;
          padQ  <= '0;
        end
      end else begin
        if (divQ == DIV_LAST) begin
          divQ <= '0;
          subQ <= (subQ == SUB_LAST) ? 5'd0 : subQ + 5'd1;
        end else begin
          divQ <= divQ + 1'b1;
        end
        if (cellEnd) begin
          case (state)
            ST_LEAD: state <= (frameLeds == '0) ? ST_TRAIL : ST_DATA;
            ST_DATA: begin
              if (posQ == POS_LAST) begin
                posQ <= '0;
                if (lastLed) state <= ST_TRAIL;
                else ledQ <= ledQ + 1'b1;
              end else begin
                posQ <= posQ + 5'd1;
              end
            end
            ST_TRAIL: begin
              if (padQ == PAD_LAST) state <= ST_IDLE;
              else padQ <= padQ + 4'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign busy           = (state != ST_IDLE);
  assign ledOut         = (state == ST_DATA) && (subQ < (rdBit ? 5'(HIGH_ONE) : 5'(HIGH_ZERO)));
  assign rdLed          = ledQ;
  assign rdPos          = posQ;
  assign ctl.txBusy     = busy;
  assign ctl.frameStart = start;

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(svcTick) && $past(pendQ))); // R7
  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    subQ <= SUB_LAST); // R2
  AST_FALL_POINT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ledOut) |-> ((divQ == '0) && (subQ == 5'(HIGH_ZERO) || subQ == 5'(HIGH_ONE)))); // R2
endmodule

// File: rtl/ledchain_tx.sv
module ledchain_tx
  import ledchain_pkg::*;
#(
  parameter int MAX_LEDS = 16,
  parameter int SUB_DIV  = 16,
  localparam int IDX_W   = $clog2(MAX_LEDS),
  localparam int CNT_W   = $clog2(MAX_LEDS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAX_LEDS-1:0] wrMask,
  input  logic [7:0]          wrRed,
  input  logic [7:0]          wrGreen,
  input  logic [7:0]          wrBlue,
  input  logic                cntEn,
  input  logic [CNT_W-1:0]    cntValue,
  input  logic                sendReq,
  input  logic                svcTick,
  output logic                ledOut,
  output logic                busy
);
  ctlStrobes_t      ctl;
  logic [IDX_W-1:0] rdLed;
  logic [4:0]       rdPos;
  logic             rdBit;
  logic [CNT_W-1:0] frameLeds;

  ledchain_ctrl #(.SUB_DIV(SUB_DIV), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sendReq(sendReq), .svcTick(svcTick),
    .frameLeds(frameLeds), .rdBit(rdBit), .ctl(ctl), .rdLed(rdLed),
    .rdPos(rdPos), .ledOut(ledOut), .busy(busy)
  );

  ledchain_pixels #(.MAX_LEDS(MAX_LEDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_pixels (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEn(wrEn), .wrMask(wrMask),
    .wrRed(wrRed), .wrGreen(wrGreen), .wrBlue(wrBlue), .cntEn(cntEn),
    .cntValue(cntValue), .rdLed(rdLed), .rdPos(rdPos), .rdBit(rdBit),
    .frameLeds(frameLeds)
  );
endmodule

// File: tb/test_ledchain_tx.sv
module test_ledchain_tx;
  localparam int NL   = 4;
  localparam int DIV  = 2;
  localparam int CW   = 3;
  localparam int CELL = 20 * DIV;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, cntEn = 0, sendReq = 0, svcTick = 0;
  logic [NL-1:0] wrMask = '0;
  logic [7:0] wrRed = 0, wrGreen = 0, wrBlue = 0;
  logic [CW-1:0] cntValue = '0;
  logic ledOut, busy;

  always #2 clk = ~clk;

  ledchain_tx #(.MAX_LEDS(NL), .SUB_DIV(DIV)) i_ledchain_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMask(wrMask), .wrRed(wrRed),
    .wrGreen(wrGreen), .wrBlue(wrBlue), .cntEn(cntEn), .cntValue(cntValue),
    .sendReq(sendReq), .svcTick(svcTick), .ledOut(ledOut), .busy(busy)
  );

  int nTests = 0, nFail = 0;
  bit doneFlag = 0;
  logic [23:0] mGrb [NL];
  int mCnt = 0;

  // {mask, green, red, blue}
  localparam logic [27:0] WR_TAB [0:5] = '{
    28'h1_12_34_56, 28'h6_A5_0F_F0, 28'h8_FF_FF_FF,
    28'h7_00_00_00, 28'h2_80_01_7E, 28'h5_FF_00_81 };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [NL-1:0] m, input logic [23:0] grb);
    @(negedge clk);
    wrEn = 1; wrMask = m; {wrGreen, wrRed, wrBlue} = grb;
    @(negedge clk);
    wrEn = 0;
  endtask

  function automatic void applyModel(input logic [NL-1:0] m, input logic [23:0] grb);
    for (int i = 0; i < NL; i++) if (m[i] && i < mCnt) mGrb[i] = grb;
  endfunction

  task automatic setCount(input int v);
    int c;
    @(negedge clk);
    cntEn = 1; cntValue = CW'(v);
    @(negedge clk);
    cntEn = 0;
    c = (v > NL) ? NL : v;
    if (c > mCnt) mCnt = c;
  endtask

  task automatic pulseReq();
    @(negedge clk); sendReq = 1;
    @(negedge clk); sendReq = 0;
  endtask

  task automatic pulseTick();
    @(negedge clk); svcTick = 1;
    @(negedge clk); svcTick = 0;
  endtask

  // decode one frame from the line against the model (R2 R3 R4)
  task automatic capture(input string tag);
    int cells, bad, firstCell, firstAct, firstExp, busyLow, wait_n, hi, exp, d;
    wait_n = 0;
    while (!busy && wait_n < 40) begin @(negedge clk); wait_n++; end
    check(busy, {tag, " R7 frame start"}, busy, 1);
    cells = 24 * mCnt + 9;
    bad = 0; busyLow = 0; firstCell = -1; firstAct = 0; firstExp = 0;
    for (int c = 0; c < cells; c++) begin
      hi = 0;
      for (int s = 0; s < CELL; s++) begin
        if (!(c == 0 && s == 0)) @(negedge clk);
        if (ledOut) hi++;
        if (!busy) busyLow++;
      end
      if (c == 0 || c > 24 * mCnt) exp = 0;
      else begin
        d = c - 1;
        exp = mGrb[d / 24][23 - (d % 24)] ? 14 * DIV : 7 * DIV;
      end
      if (hi != exp) begin
        bad++;
        if (firstCell < 0) begin firstCell = c; firstAct = hi; firstExp = exp; end
      end
    end
    check(bad == 0, {tag, " R2 R3 cell high time"}, firstAct, firstExp);
    @(negedge clk);
    check(busyLow == 0 && !busy, {tag, " R4 frame length"}, busyLow + int'(busy), 0);
  endtask

  task automatic sendFrame(input string tag);
    pulseReq();
    pulseTick();
    capture(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) mGrb[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!ledOut && !busy, "R1 reset outputs", {ledOut, busy}, 0);

    // zero-length chain: pads only (R4)
    sendFrame("R4 empty chain");

    // grow chain and send reset pixel content (R1, R6)
    setCount(3);
    sendFrame("R1 zero pixels");

    // table walk: masked colour writes (R5), each followed by a frame
    for (int v = 0; v < 6; v++) begin
      doWrite(WR_TAB[v][27:24], WR_TAB[v][23:0]);
      applyModel(WR_TAB[v][27:24], WR_TAB[v][23:0]);
      sendFrame($sformatf("R5 vector %0d", v));
    end

    // shrink attempt ignored (R6)
    setCount(2);
    doWrite(4'hF, 24'h3C_C3_5A);
    applyModel(4'hF, 24'h3C_C3_5A);
    sendFrame("R6 no shrink");

    // clamp to maximum; LED 3 was never written (R6, R5)
    setCount(7);
    sendFrame("R6 clamp max");
    doWrite(4'h8, 24'h01_02_04);
    applyModel(4'h8, 24'h01_02_04);
    sendFrame("R5 top LED");

    // request alone does not start a frame (R7)
    pulseReq();
    repeat (30) @(negedge clk);
    check(!busy, "R7 no start without tick", busy, 0);
    // tick alone with nothing pending: covered after the next frame
    pulseTick();
    capture("R7 tick starts pending");
    pulseTick();
    repeat (5) @(negedge clk);
    check(!busy, "R7 tick without pending", busy, 0);

    // request during a frame is kept (R7)
    pulseReq();
    pulseTick();
    fork
      capture("R7 first frame");
      begin repeat (200) @(negedge clk); sendReq = 1; @(negedge clk); sendReq = 0; end
    join
    repeat (10) @(negedge clk);
    check(!busy, "R7 waits for tick", busy, 0);
    pulseTick();
    capture("R7 kept request");

    // writes during a frame are held, latest wins (R8)
    pulseReq();
    pulseTick();
    fork
      capture("R8 frame unaffected");
      begin
        repeat (300) @(negedge clk);
        doWrite(4'h1, 24'hAA_AA_AA);
        repeat (10) @(negedge clk);
        doWrite(4'h2, 24'h0F_F0_33);
      end
    join
    applyModel(4'h2, 24'h0F_F0_33);
    sendFrame("R8 latest held write applied");

    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule